// File: doc/BRIEF.md
# APB Protocol Compliance Monitor

This block is a passive observer for one APB requester-to-completer link. It samples the select, enable, direction, address, write data, ready and read data signals on every rising clock edge. It never drives the bus. It follows the bus through its phases, and in every cycle it tests the rule that applies to that phase. When a cycle breaks a rule, the monitor reports which rule broke: the idle rule, the setup, first-access, wait and wait-end rules (each in a write and a read form), or one of the two exit rules.

A violation produces a one-cycle pulse with a 4-bit code. The same violation also sets a bit in a sticky vector, which only reset clears. Three saturating counters record completed writes, completed reads and wait cycles, so an environment can check the mix of traffic that passed. The read data of the last completed read is held on an output.

The tracker has four named states:
- `PH_IDLE` expects an idle cycle or a setup cycle.
- `PH_ACCESS` is the first access cycle.
- `PH_WAIT` covers the access cycles that follow a wait.
- `PH_EXIT` is the cycle after a completion.

The transitions are:
- **setup-taken**: `PH_IDLE`→`PH_ACCESS`, and also `PH_EXIT`→`PH_ACCESS`.
- **stall**: `PH_ACCESS`/`PH_WAIT`→`PH_WAIT`.
- **complete**: `PH_ACCESS`/`PH_WAIT`→`PH_EXIT`.
- **exit-idle**: `PH_EXIT`→`PH_IDLE`.
- **resync**: any state→`PH_IDLE`, after a violation or while reset is held.

Top module: `apb_protocol_monitor`

## Requirements
- R1: While rst_n is low, no check runs and every output reads zero. When reset is released, tracking starts in the idle phase, so a cycle with select and enable both high right after reset is judged as a setup cycle.
- R2: In the idle phase, a cycle with select low and enable low is legal. A cycle with select low and enable high is an idle violation, code 1.
- R3: The first cycle with select high after idle is the setup cycle, and enable must be low there. If enable is high, it is a setup violation: code 2 when the write line is high, code 6 when it is low.
- R4: The first access cycle must keep select and enable high. Address and direction must match the setup cycle, and for writes so must the write data. If ready is high in this cycle and the rule breaks, the code is 3 for a write or 7 for a read.
- R5: Access cycles with ready low are wait cycles, and any number of them is allowed. They obey the same stability rule as R4. A violation in a wait cycle gives code 4 for a write or 8 for a read.
- R6: An access cycle with ready high that follows at least one wait cycle completes the transfer under the same stability rule. A violation there gives code 5 for a write or 9 for a read.
- R7: The cycle after a completion is legal in two cases: select and enable both low, or select high with enable low. The second case is a back-to-back setup and is taken as a new setup in that same cycle. Select low with enable high gives code 10. Select high with enable high gives code 11.
- R8: err_valid is high for exactly the one cycle that follows the violating cycle (one register stage), with err_code holding the code. In all other cycles err_valid is low and err_code is 0.
- R9: err_sticky bit k is set when code k is reported. Bits only accumulate, and only reset clears them.
- R10: wr_count and rd_count rise by one on the edge that ends a legal completing cycle. wait_count rises by one for each legal wait cycle. A completion that breaks a rule is not counted. Each counter saturates at 2^CW-1.
- R11: rd_data_last takes bus_rdata on a legal read completion and holds it through all other cycles, including write completions.
- R12: After any violation the tracker returns to the idle phase. The next cycle is therefore judged by the idle and setup rules (R2, R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Completer select |
| bus_enable | input | 1 | Access-phase enable |
| bus_write | input | 1 | Direction, high for write |
| bus_addr | input | AW | Transfer address |
| bus_wdata | input | DW | Write data |
| bus_ready | input | 1 | Completer ready |
| bus_rdata | input | DW | Read data from completer |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 4 | Code of the reported violation, 0 when none |
| err_sticky | output | 12 | Accumulated violations, bit k for code k |
| wr_count | output | CW | Completed writes, saturating |
| rd_count | output | CW | Completed reads, saturating |
| wait_count | output | CW | Wait cycles, saturating |
| rd_data_last | output | DW | Read data of the last completed read |

## Verification
The assertions take for granted that reset is held low from time zero until after the first clock edge, and that every bus input carries a known value at each sampled edge. Without that, the count-step and sticky-growth properties would compare against undefined history. The bench holds rst_n low over the first edges and starts every scenario with a fresh reset. It drives all bus inputs to defined values one time unit after each rising edge and never leaves them floating. This also keeps the design inputs stable across every sampling edge, which the stability rules depend on.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

    localparam int ERR_CODE_W = 4;
    localparam int ERR_NUM    = 12;

    // Tracked bus phase: what the current cycle is expected to be.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_WAIT   = 2'd2,
        PH_EXIT   = 2'd3
    } phase_t;

    typedef enum logic [ERR_CODE_W-1:0] {
        ERR_NONE       = 4'd0,
        ERR_IDLE       = 4'd1,
        ERR_WR_SETUP   = 4'd2,
        ERR_WR_ACCESS  = 4'd3,
        ERR_WR_WAIT    = 4'd4,
        ERR_WR_WAITEND = 4'd5,
        ERR_RD_SETUP   = 4'd6,
        ERR_RD_ACCESS  = 4'd7,
        ERR_RD_WAIT    = 4'd8,
        ERR_RD_WAITEND = 4'd9,
        ERR_EXIT_IDLE  = 4'd10,
        ERR_EXIT_SETUP = 4'd11,
        ERR_RSVD_12    = 4'd12,
        ERR_RSVD_13    = 4'd13,
        ERR_RSVD_14    = 4'd14,
        ERR_RSVD_15    = 4'd15
    } err_code_t;

endpackage

// File: rtl/apb_mon_phase.sv
module apb_mon_phase
    import apb_mon_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          enable,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          ready,
    input  logic [DW-1:0] rdata,
    output logic          viol,
    output err_code_t     code,
    output logic          done_wr,
    output logic          done_rd,
    output logic          wait_tick,
    output logic [DW-1:0] rd_last
);

    phase_t        ph_q;
    phase_t        ph_d;
    logic [AW-1:0] addr_q;
    logic          wr_q;
    logic [DW-1:0] wdata_q;
    logic          capture;
    logic          hold_ok;

    // Code for an access-phase violation: direction from the setup snapshot,
    // wait history from the phase, completion from ready.
    function automatic err_code_t access_code(input logic wr, input logic waited,
                                              input logic rdy);
        err_code_t c;
        if (wr) begin
            if (!waited) c = rdy ? ERR_WR_ACCESS : ERR_WR_WAIT;
            else         c = rdy ? ERR_WR_WAITEND : ERR_WR_WAIT;
        end else begin
            if (!waited) c = rdy ? ERR_RD_ACCESS : ERR_RD_WAIT;
            else         c = rdy ? ERR_RD_WAITEND : ERR_RD_WAIT;
        end
        return c;
    endfunction

    // Access-phase stability against the setup snapshot.
    always_comb begin
        hold_ok = sel && enable && (addr == addr_q) && (write == wr_q)
                  && (!wr_q || (wdata == wdata_q));
    end

    // Phase register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Rule evaluation and next phase.
    always_comb begin
        ph_d      = ph_q;
        viol      = 1'b0;
        code      = ERR_NONE;
        done_wr   = 1'b0;
        done_rd   = 1'b0;
        wait_tick = 1'b0;
        capture   = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (!sel) begin
                    if (enable) begin
                        viol = 1'b1;
                        code = ERR_IDLE;
                    end
                end else if (enable) begin
                    viol = 1'b1;
                    code = write ? ERR_WR_SETUP : ERR_RD_SETUP;
                end else begin
                    capture = 1'b1;
                    ph_d    = PH_ACCESS;
                end
            end
            PH_ACCESS, PH_WAIT: begin
                if (!hold_ok) begin
                    viol = 1'b1;
                    code = access_code(wr_q, ph_q == PH_WAIT, ready);
                    ph_d = PH_IDLE;
                end else if (ready) begin
                    done_wr = wr_q;
                    done_rd = !wr_q;
                    ph_d    = PH_EXIT;
                end else begin
                    wait_tick = 1'b1;
                    ph_d      = PH_WAIT;
                end
            end
            PH_EXIT: begin
                if (!enable) begin
                    if (sel) begin
                        capture = 1'b1;
                        ph_d    = PH_ACCESS;
                    end else begin
                        ph_d = PH_IDLE;
                    end
                end else begin
                    viol = 1'b1;
                    code = sel ? ERR_EXIT_SETUP : ERR_EXIT_IDLE;
                    ph_d = PH_IDLE;
                end
            end
        endcase
    end

    // Setup snapshot and read-data capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rd_last <= '0;
        end else begin
            if (capture) begin
                addr_q  <= addr;
                wr_q    <= write;
                wdata_q <= wdata;
            end
            if (done_rd) rd_last <= rdata;
        end
    end

endmodule

// File: rtl/apb_mon_report.sv
module apb_mon_report
    import apb_mon_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hit,
    input  err_code_t             code,
    output logic                  err_valid,
    output logic [ERR_CODE_W-1:0] err_code,
    output logic [ERR_NUM-1:0]    err_sticky
);

    localparam logic [ERR_NUM-1:0] ONE_HOT_BASE = {{(ERR_NUM-1){1'b0}}, 1'b1};

    logic [ERR_NUM-1:0] hit_mask;

    always_comb begin
        hit_mask = hit ? (ONE_HOT_BASE << code) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_valid  <= 1'b0;
            err_code   <= '0;
            err_sticky <= '0;
        end else begin
            err_valid  <= hit;
            err_code   <= hit ? code : ERR_NONE;
            err_sticky <= err_sticky | hit_mask;
        end
    end

endmodule

// File: rtl/apb_mon_satcnt.sv
module apb_mon_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (inc && (count != MAX)) count <= count + 1'b1;
    end

endmodule

// File: rtl/apb_protocol_monitor.sv
module apb_protocol_monitor
    import apb_mon_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_enable,
    input  logic                  bus_write,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    input  logic                  bus_ready,
    input  logic [DW-1:0]         bus_rdata,
    output logic                  err_valid,
    output logic [ERR_CODE_W-1:0] err_code,
    output logic [ERR_NUM-1:0]    err_sticky,
    output logic [CW-1:0]         wr_count,
    output logic [CW-1:0]         rd_count,
    output logic [CW-1:0]         wait_count
,
    output logic [DW-1:0]         rd_data_last
);

    localparam int NCNT = 3;

    logic            viol;
    err_code_t       code;
    logic            done_wr;
    logic            done_rd;
    logic            wait_tick;
    logic [NCNT-1:0] inc_vec;
    logic [CW-1:0]   cnt_arr [NCNT];

    apb_mon_phase #(.AW(AW), .DW(DW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (bus_sel),
        .enable    (bus_enable),
        .write     (bus_write),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ready     (bus_ready),
        .rdata     (bus_rdata),
        .viol      (viol),
        .code      (code),
        .done_wr   (done_wr),
        .done_rd   (done_rd),
        .wait_tick (wait_tick),
        .rd_last   (rd_data_last)
    );

    apb_mon_report u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (viol),
        .code       (code),
        .err_valid  (err_valid),
        .err_code   (err_code),
        .err_sticky (err_sticky)
    );

    assign inc_vec = {wait_tick, done_rd, done_wr};

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        apb_mon_satcnt #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[g]),
            .count (cnt_arr[g])
        );
    end

    assign wr_count   = cnt_arr[0];
    assign rd_count   = cnt_arr[1];
    assign wait_count = cnt_arr[2];

endmodule

// File: rtl/apb_mon_checker.sv
module apb_mon_checker
    import apb_mon_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  err_valid,
    input logic [ERR_CODE_W-1:0] err_code,
    input logic [ERR_NUM-1:0]    err_sticky,
    input logic [CW-1:0]         wr_count,
    input logic [CW-1:0]         rd_count,
    input logic [CW-1:0]         wait_count,
    input logic [DW-1:0]         rd_data_last
);

    a_r8_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code != 4'd0 && err_code <= 4'd11));

    a_r8_quiet_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> (err_code == 4'd0));

    a_r9_pulse_in_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_sticky[err_code]);

    a_r9_sticky_grows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

    a_r10_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_count == $past(wr_count) || wr_count == $past(wr_count) + 1'b1));

    a_r10_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_count == $past(rd_count) || rd_count == $past(rd_count) + 1'b1));

    a_r10_wait_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wait_count == $past(wait_count) || wait_count == $past(wait_count) + 1'b1));

    a_r11_rdata_moves_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data_last) |-> (!$stable(rd_count) || (&rd_count)));

endmodule

bind apb_protocol_monitor apb_mon_checker #(.DW(DW), .CW(CW)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_valid    (err_valid),
    .err_code     (err_code),
    .err_sticky   (err_sticky),
    .wr_count     (wr_count),
    .rd_count     (rd_count),
    .wait_count   (wait_count),
    .rd_data_last (rd_data_last)
);

// File: tb/apb_protocol_monitor_test.sv
module apb_protocol_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        en = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rdy = 1'b0;
    logic [31:0] rdata = '0;
    logic        err_valid;
    logic [3:0]  err_code;
    logic [11:0] err_sticky;
    logic [15:0] wr_count;
    logic [15:0] rd_count;
    logic [15:0] wait_count;
    logic [31:0] rd_data_last;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    apb_protocol_monitor uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_enable(en), .bus_write(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_ready(rdy), .bus_rdata(rdata),
        .err_valid(err_valid), .err_code(err_code), .err_sticky(err_sticky),
        .wr_count(wr_count), .rd_count(rd_count), .wait_count(wait_count),
        .rd_data_last(rd_data_last)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic s, input logic e, input logic w, input logic [31:0] a,
                         input logic [31:0] d, input logic r, input logic [31:0] rd);
        sel = s; en = e; wr = w; addr = a; wdata = d; rdy = r; rdata = rd;
    endtask

    task automatic idle();
        drive(0, 0, 0, 32'h0, 32'h0, 0, 32'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        step();
        step();
        rst_n = 1'b1;
    endtask

    // Setup, then 'waits' wait cycles, then a completing cycle (no idle after).
    task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input int waits, input logic [31:0] rd);
        drive(1, 0, w, a, d, 0, 32'h0);
        step();
        for (int i = 0; i < waits; i++) begin
            drive(1, 1, w, a, d, 0, 32'hDEAD_0000 + i);
            step();
        end
        drive(1, 1, w, a, d, 1, rd);
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1, 1, 1, 32'h10, 32'h1, 1, 32'h2);
        step();
        step();
        check("R1 err_valid in reset", err_valid, 0);
        check("R1 sticky in reset", err_sticky, 0);
        check("R1 counters in reset", {wr_count, rd_count, wait_count}, 0);
        check("R1 rd_data_last in reset", rd_data_last, 0);
        idle();
        rst_n = 1'b1;
        drive(1, 0, 1, 32'h20, 32'h5, 0, 0);
        step();
        drive(1, 1, 1, 32'h20, 32'h5, 0, 0);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        drive(1, 1, 1, 32'h20, 32'h5, 1, 0);
        step();
        check("R1 phase back to idle after reset", err_code, 2);
        check("R1 no count after reset", wr_count, 0);
    endtask

    task automatic t_idle();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            idle();
            step();
        end
        check("R2 long idle legal", err_sticky, 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        step();
        check("R2 enable without select", err_valid, 1);
        check("R8 code idle", err_code, 1);
        idle();
        step();
        check("R8 pulse one cycle", err_valid, 0);
        check("R8 code cleared", err_code, 0);
        check("R9 idle bit sticky", err_sticky, 12'h002);
    endtask

    task automatic t_write_nowait();
        do_reset();
        xfer(1, 32'h100, 32'hA5A5_0001, 0, 0);
        check("R10 write counted", wr_count, 1);
        check("R4 no error no-wait write", err_sticky, 0);
        idle();
        step();
        check("R7 exit to idle legal", err_valid, 0);
        check("R10 no waits", wait_count, 0);
    endtask

    task automatic t_read_wait();
        do_reset();
        xfer(0, 32'h200, 32'h0, 3, 32'hCAFE_F00D);
        check("R5 three waits legal", err_sticky, 0);
        check("R10 wait cycles", wait_count, 3);
        check("R10 read counted", rd_count, 1);
        check("R11 read data captured", rd_data_last, 32'hCAFE_F00D);
        idle();
        step();
        xfer(1, 32'h204, 32'h1111_2222, 1, 32'h7777_7777);
        idle();
        step();
        check("R11 held across write", rd_data_last, 32'hCAFE_F00D);
        check("R6 legal wait end", err_sticky, 0);
    endtask

    task automatic t_back_to_back();
        do_reset();
        xfer(1, 32'h300, 32'h1, 0, 0);
        xfer(0, 32'h304, 32'h0, 2, 32'h4444);
        xfer(1, 32'h308, 32'h2, 0, 0);
        idle();
        step();
        check("R7 back-to-back legal", err_sticky, 0);
        check("R7 counts", {wr_count, rd_count, wait_count}, {16'd2, 16'd1, 16'd2});
    endtask

    task automatic t_setup_err();
        do_reset();
        drive(1, 1, 1, 32'h40, 0, 0, 0);
        step();
        check("R3 write setup violation", err_code, 2);
        idle();
        step();
        drive(1, 1, 0, 32'h40, 0, 0, 0);
        step();
        check("R3 read setup violation", err_code, 6);
        idle();
        step();
        check("R9 sticky accumulates", err_sticky, 12'h044);
    endtask

    task automatic t_access_err();
        do_reset();
        drive(1, 0, 1, 32'h50, 32'h9, 0, 0);
        step();
        drive(1, 1, 1, 32'h54, 32'h9, 1, 0);
        step();
        check("R4 write address change", err_code, 3);
        check("R10 violating completion not counted", wr_count, 0);
        xfer(1, 32'h58, 32'h9, 0, 0);
        check("R12 resync then legal write", err_sticky, 12'h008);
        check("R12 write after resync counted", wr_count, 1);
        idle();
        step();
        do_reset();
        drive(1, 0, 0, 32'h60, 0, 0, 0);
        step();
        drive(1, 1, 1, 32'h60, 0, 1, 0);
        step();
        check("R4 read direction change", err_code, 7);
    endtask

    task automatic t_wait_err();
        do_reset();
        drive(1, 0, 0, 32'h70, 0, 0, 0);
        step();
        drive(0, 1, 0, 32'h70, 0, 0, 0);
        step();
        check("R5 read select dropped in wait", err_code, 8);
        idle();
        step();
        drive(1, 0, 1, 32'h74, 32'h33, 0, 0);
        step();
        drive(1, 1, 1, 32'h74, 32'h33, 0, 0);
        step();
        drive(1, 1, 1, 32'h74, 32'h34, 0, 0);
        step();
        check("R5 write data change in wait", err_code, 4);
        check("R10 only legal wait counted", wait_count, 1);
        idle();
        step();
    endtask

    task automatic t_waitend_err();
        do_reset();
        drive(1, 0, 1, 32'h80, 32'h5, 0, 0);
        step();
        drive(1, 1, 1, 32'h80, 32'h5, 0, 0);
        step();
        drive(1, 1, 1, 32'h80, 32'h5, 0, 0);
        step();
        drive(1, 1, 1, 32'h84, 32'h5, 1, 0);
        step();
        check("R6 write wait end violation", err_code, 5);
        check("R6 waits before violation", wait_count, 2);
        check("R6 not counted", wr_count, 0);
        idle();
        step();
        drive(1, 0, 0, 32'h90, 0, 0, 0);
        step();
        drive(1, 1, 0, 32'h90, 0, 0, 0);
        step();
        drive(1, 0, 0, 32'h90, 0, 1, 32'h55);
        step();
        check("R6 read wait end violation", err_code, 9);
        check("R11 no capture on violation", rd_data_last, 0);
        idle();
        step();
    endtask

    task automatic t_exit_err();
        do_reset();
        xfer(1, 32'hA0, 32'h1, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        step();
        check("R7 exit to idle violation", err_code, 10);
        idle();
        step();
        do_reset();
        xfer(0, 32'hA4, 32'h0, 0, 32'h9);
        drive(1, 1, 0, 32'hA8, 0, 0, 0);
        step();
        check("R7 exit to setup violation", err_code, 11);
        idle();
        step();
    endtask

    task automatic t_saturate();
        do_reset();
        xfer(0, 32'hB0, 32'h0, 65540, 32'hBEEF);
        check("R10 wait counter saturates", wait_count, 16'hFFFF);
        check("R10 read after long wait", rd_count, 1);
        idle();
        step();
    endtask

    initial begin
        t_reset();
        t_idle();
        t_write_nowait();
        t_read_wait();
        t_back_to_back();
        t_setup_err();
        t_access_err();
        t_wait_err();
        t_waitend_err();
        t_exit_err();
        t_saturate();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule